// File: doc/BRIEF.md
# Bidirectional Serial Frequency-Word Loader

This block builds a 64-bit frequency register one bit at a time from a single serial data pin, clocked by its own serial clock. A direction input, sampled on every serial clock edge, decides whether the incoming stream is treated as most-significant-bit first or least-significant-bit first. Because of that, the same stream can end up in either half of the register.

The register holds two 32-bit frequency words. A select input chooses which half drives the 32-bit output, and that output feeds a downstream phase accumulator. Two tones can be loaded once and then switched with the select line alone, which suits frequency-shift keying.

For single-word use, tie the select and direction inputs to the same level. A word shifted MSB first settles in the lower half, and a word shifted LSB first settles in the upper half.

Top module: `fwl_freq_loader`

## Requirements
- R1: An active-low asynchronous reset clears all 64 register bits to zero, so the output reads zero with either select value.
- R2: While `shift_en_n` is high, the register keeps its contents across any number of serial clock rising edges.
- R3: On a rising edge of `sclk` with `shift_en_n` low and `msb_first` high (1), the `sdata` bit enters bit 0 and every other bit moves one place toward bit 63. The old bit 63 is discarded.
- R4: On a rising edge of `sclk` with `shift_en_n` low and `msb_first` low (0), the `sdata` bit enters bit 63 and every other bit moves one place toward bit 0. The old bit 0 is discarded.
- R5: With `sel_low` high (1), `word_out` shows register bits 31..0. With `sel_low` low (0), it shows bits 63..32. The output follows `sel_low` without waiting for a clock edge.
- R6: After 32 bits of a word are shifted MSB first, the word is read with `sel_low` high. After 32 bits are shifted LSB first, the word is read with `sel_low` low.
- R7: Direction is taken per edge, so a stream that changes `msb_first` between bits updates the register according to each edge's own direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock; the register shifts on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sdata | input | 1 | Serial data bit |
| shift_en_n | input | 1 | Active-low shift enable |
| msb_first | input | 1 | 1: bit enters at bit 0 (MSB first); 0: bit enters at bit 63 (LSB first) |
| sel_low | input | 1 | 1: output bits 31..0; 0: output bits 63..32 |
| word_out | output | 32 | Selected frequency word |

## Verification
The assertions take for granted the following:
- `sdata`, `shift_en_n` and `msb_first` are settled and known at every rising `sclk` edge.
- Reset is released away from that edge.

The stimulus keeps to these conditions by driving all inputs on the falling edge. The directed sequences cover:
- full 32-bit loads in each direction;
- enable-high stretches;
- a reset in the middle of the run.

Random stimulus mixes direction and enable changes on every edge. Both halves are compared after each edge by toggling the select between reads.

// File: rtl/fwl_pkg.sv
package fwl_pkg;
   typedef enum logic {
      DIR_LSB_FIRST = 1'b0,
      DIR_MSB_FIRST = 1'b1
   } fwl_dir_e;

   typedef enum logic {
      HALF_UPPER = 1'b0,
      HALF_LOWER = 1'b1
   } fwl_half_e;
endpackage

// File: rtl/fwl_bit_cell.sv
module fwl_bit_cell
   import fwl_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic shift_en_n,
   input  logic dir,
   input  logic from_lower,
   input  logic from_upper,
   output logic q
);
   logic d_next;

   always_comb begin
      if (shift_en_n)
         d_next = q;
      else if (fwl_dir_e'(dir) == DIR_MSB_FIRST)
         d_next = from_lower;
      else
         d_next = from_upper;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= 1'b0;
      else
         q <= d_next;
   end
endmodule

// File: rtl/fwl_shift_reg.sv
module fwl_shift_reg #(
   parameter int REG_W = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sdata,
   input  logic             shift_en_n,
   input  logic             msb_first,
   output logic [REG_W-1:0] q
);
   localparam int TOP = REG_W - 1;

   logic [REG_W-1:0] lower_src;
   logic [REG_W-1:0] upper_src;

   generate
      if (REG_W < 2) begin : g_bad_width
         $error("fwl_shift_reg: REG_W must be at least 2");
      end

      for (genvar i = 0; i < REG_W; i++) begin : g_cell
         if (i == 0) begin : g_lo_edge
            assign lower_src[i] = sdata;
         end else begin : g_lo_mid
            assign lower_src[i] = q[i-1];
         end

         if (i == TOP) begin : g_hi_edge
            assign upper_src[i] = sdata;
         end else begin : g_hi_mid
            assign upper_src[i] = q[i+1];
         end

         fwl_bit_cell u_cell (
            .clk        (clk),
            .rst_n      (rst_n),
            .shift_en_n (shift_en_n),
            .dir        (msb_first),
            .from_lower (lower_src[i]),
            .from_upper (upper_src[i]),
            .q          (q[i])
         );
      end
   endgenerate

   // R2: register frozen while shifting is disabled
   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      shift_en_n |=> $stable(q));

   // R3: MSB-first entry point at bit 0
   p_msb_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!shift_en_n && msb_first) |=> (q[0] == $past(sdata)));

   // R3: MSB-first contents move toward the top
   p_msb_move_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!shift_en_n && msb_first) |=> (q[TOP:1] == $past(q[TOP-1:0])));

   // R4: LSB-first entry point at the top bit
   p_lsb_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!shift_en_n && !msb_first) |=> (q[TOP] == $past(sdata)));

   // R4: LSB-first contents move toward bit 0
   p_lsb_move_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!shift_en_n && !msb_first) |=> (q[TOP-1:0] == $past(q[TOP:1])));
endmodule

// File: rtl/fwl_word_mux.sv
module fwl_word_mux
   import fwl_pkg::*;
#(
   parameter int WORD_W = 32,
   parameter int REG_W  = 64
) (
   input  logic [REG_W-1:0]  reg_i,
   input  logic              sel_low,
   output logic [WORD_W-1:0] word_o
);
   localparam int NUM_WORDS = REG_W / WORD_W;

   logic [WORD_W-1:0] half_lo;
   logic [WORD_W-1:0] half_hi;

   generate
      if (NUM_WORDS != 2 || (REG_W % WORD_W) != 0) begin : g_bad_split
         $error("fwl_word_mux: REG_W must be exactly twice WORD_W");
      end
   endgenerate

   assign half_lo = reg_i[WORD_W-1:0];
   assign half_hi = reg_i[REG_W-1:REG_W-WORD_W];

   always_comb begin
      if (fwl_half_e'(sel_low) == HALF_LOWER)
         word_o = half_lo;
      else
         word_o = half_hi;
   end
endmodule

// File: rtl/fwl_freq_loader.sv
module fwl_freq_loader #(
   parameter int WORD_W = 32,
   parameter int REG_W  = 2 * WORD_W
) (
   input  logic              sclk,
   input  logic              rst_n,
   input  logic              sdata,
   input  logic              shift_en_n,
   input  logic              msb_first,
   input  logic              sel_low,
   output logic [WORD_W-1:0] word_out
);
   logic [REG_W-1:0] freq_reg;

   generate
      if (WORD_W < 1) begin : g_bad_word
         $error("fwl_freq_loader: WORD_W must be positive");
      end
   endgenerate

   fwl_shift_reg #(.REG_W(REG_W)) u_shift (
      .clk        (sclk),
      .rst_n      (rst_n),
      .sdata      (sdata),
      .shift_en_n (shift_en_n),
      .msb_first  (msb_first),
      .q          (freq_reg)
   );

   fwl_word_mux #(.WORD_W(WORD_W), .REG_W(REG_W)) u_mux (
      .reg_i   (freq_reg),
      .sel_low (sel_low),
      .word_o  (word_out)
   );

   // R5: with shifting disabled the selected word is steady while the select is steady
   p_word_steady_r5: assert property (@(posedge sclk) disable iff (!rst_n)
      (shift_en_n && $stable(sel_low)) |=> $stable(word_out));
endmodule

// File: tb/fwl_freq_loader_bench.sv
module fwl_freq_loader_bench;
   logic        sclk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sdata = 1'b0;
   logic        shift_en_n = 1'b1;
   logic        msb_first = 1'b1;
   logic        sel_low = 1'b1;
   logic [31:0] word_out;

   logic [63:0] model = '0;
   int          n_checks = 0;
   int          n_fail = 0;
   bit          done = 1'b0;

   always #5 sclk = ~sclk;

   fwl_freq_loader u_fwl_freq_loader (
      .sclk       (sclk),
      .rst_n      (rst_n),
      .sdata      (sdata),
      .shift_en_n (shift_en_n),
      .msb_first  (msb_first),
      .sel_low    (sel_low),
      .word_out   (word_out)
   );

   function automatic logic [63:0] next_model(logic [63:0] cur, logic d, logic en_n, logic dir);
      if (en_n)
         return cur;
      if (dir)
         return {cur[62:0], d};
      return {d, cur[63:1]};
   endfunction

   task automatic check_word(string tag, logic [31:0] exp);
      n_checks++;
      if (word_out !== exp) begin
         n_fail++;
         $display("FAIL %s: word_out=%08h expected=%08h", tag, word_out, exp);
      end
   endtask

   task automatic check_both(string tag);
      sel_low = 1'b1;
      #1;
      check_word({tag, " R5 lower"}, model[31:0]);
      sel_low = 1'b0;
      #1;
      check_word({tag, " R5 upper"}, model[63:32]);
   endtask

   task automatic step(logic d, logic en_n, logic dir, string tag);
      @(negedge sclk);
      sdata      = d;
      shift_en_n = en_n;
      msb_first  = dir;
      @(posedge sclk);
      model = next_model(model, d, en_n, dir);
      #2;
      check_both(tag);
   endtask

   initial begin
      logic [31:0] w;
      void'($urandom(32'd1234));

      #12;
      check_both("R1 reset");
      @(negedge sclk);
      rst_n = 1'b1;

      // R6: single word MSB first, read with sel high
      w = 32'hA5C3_1E27;
      for (int i = 31; i >= 0; i--) begin
         @(negedge sclk);
         sdata = w[i]; shift_en_n = 1'b0; msb_first = 1'b1;
         @(posedge sclk);
         model = next_model(model, w[i], 1'b0, 1'b1);
      end
      #2;
      sel_low = 1'b1;
      #1;
      check_word("R6 msb-first word", w);
      check_word("R3 msb-first model", model[31:0]);

      // R2: hold with enable high, data toggling
      for (int i = 0; i < 6; i++)
         step(i[0], 1'b1, i[1], "R2 hold");

      // R6: single word LSB first, read with sel low
      w = 32'h1234_F0E1;
      for (int i = 0; i < 32; i++) begin
         @(negedge sclk);
         sdata = w[i]; shift_en_n = 1'b0; msb_first = 1'b0;
         @(posedge sclk);
         model = next_model(model, w[i], 1'b0, 1'b0);
      end
      #2;
      sel_low = 1'b0;
      #1;
      check_word("R6 lsb-first word", w);
      check_word("R4 lsb-first model", model[63:32]);

      // R3/R4/R7: random mixed stream
      for (int i = 0; i < 1500; i++) begin
         logic d, en_n, dir;
         d    = 1'($urandom);
         en_n = (($urandom % 4) == 0);
         dir  = 1'($urandom);
         step(d, en_n, dir, dir ? "R3 R7 random" : "R4 R7 random");
      end

      // R1: asynchronous reset mid-run
      @(negedge sclk);
      #2;
      rst_n = 1'b0;
      model = '0;
      #1;
      check_both("R1 async reset");
      @(negedge sclk);
      rst_n = 1'b1;
      step(1'b1, 1'b0, 1'b0, "R4 after reset");
      step(1'b1, 1'b0, 1'b1, "R3 after reset");

      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (100000) @(posedge sclk);
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
         end
      join_any
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end
endmodule